// File: doc/BRIEF.md
# Control signal glitch filter

This block conditions three slow video control lines in the pixel clock domain before a link framer packs them. Bits 0 and 1 of the control bus are fast-rule lines. Bit 2 is a slow-rule line. Each line has its own filter. A filter passes a new level only when two conditions hold: the level has been present for that line's minimum pulse width, and the line's history of recently accepted edges still has room in a 130-cycle window. An edge that fails either condition does not reach the output, and the output keeps its last accepted level.

There are three operating modes, set by two inputs. With `norm_mode_i` high and `filt_en_i` high, the fast lines need three stable cycles before a new level passes. With `norm_mode_i` high and `filt_en_i` low, the fast lines have no minimum width, but the edge-count limit still applies. With `norm_mode_i` low, the block is in compatibility mode: every filter and window is bypassed, and each output is simply the input registered once. The slow line always needs 130 stable cycles in the normal modes, whatever `filt_en_i` says.

Top module: `ctrl_glitch_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `ctl_o` becomes 3'b000 after that edge, whatever the inputs or mode. The reset also clears all stability counts and edge histories.
- R2: In normal mode with `filt_en_i` high, a new level on `ctl_i[0]` or `ctl_i[1]` that is held for at least 3 cycles appears on the output 4 cycles after the input changes.
- R3: In normal mode with `filt_en_i` high, a level on `ctl_i[0]` or `ctl_i[1]` that lasts 1 or 2 cycles never changes the output.
- R4: If an input goes back to the current output level before it qualifies, the pending level is discarded. A later change is timed from its own latest edge, not from the earlier attempt.
- R5: In normal mode with `filt_en_i` low, a new level on `ctl_i[0]` or `ctl_i[1]` that is held for even one cycle appears on the output 2 cycles after the input changes, provided the window allows it (R6).
- R6: In normal mode, each of `ctl_o[0]` and `ctl_o[1]` makes at most 2 transitions in any 130 consecutive cycles. A qualified level that is blocked is dropped. It passes at the first cycle the window frees only if the input still holds it then.
- R7: In normal mode, a new level on `ctl_i[2]` reaches `ctl_o[2]` only after 130 stable cycles, which is 131 cycles after the input changes. Shorter pulses are dropped. `filt_en_i` has no effect on this line.
- R8: In normal mode, `ctl_o[2]` makes at most 1 transition in any 130 consecutive cycles.
- R9: With `norm_mode_i` low, every `ctl_o` bit equals its `ctl_i` bit one cycle later. Pulses of any width pass, and `filt_en_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| norm_mode_i | input | 1 | 1 = normal (filtered) mode, 0 = compatibility bypass |
| filt_en_i | input | 1 | 1 = 3-cycle minimum width on fast lines (normal mode only) |
| ctl_i | input | 3 | Raw control lines; bits 1:0 fast-rule, bit 2 slow-rule |
| ctl_o | output | 3 | Filtered control lines, held at last accepted level |

## Verification
Every output edge is due a fixed number of cycles after the input edge that causes it. That number is 4 for a fast line with the filter on, 2 for a fast line with the filter off, 131 for the slow line and 1 in bypass. When a fast line is held back by its window, the edge is due 130 cycles after the older accepted edge. The driver computes each due cycle from these rules when it drives the input, and it queues the expected output vector tagged with that cycle. The monitor samples on the falling edge and pairs each output change it sees with the head of the queue, so an edge that is early, late or spurious shows up as a mismatch. Leftover queue entries at the end of a phase count as missed edges.

// File: rtl/cgf_pkg.sv
package cgf_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_PLAIN  = 2'b01,
        MODE_FILT   = 2'b10
    } cgf_mode_e;

    function automatic int cgf_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cgf_window.sv
module cgf_window #(
    parameter int WIN   = 130,
    parameter int SLOTS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic take_i,
    output logic free_o
);
    localparam int AW = $clog2(WIN + 1);
    localparam logic [AW-1:0] FULL = AW'(WIN);

    logic [AW-1:0] age_d [SLOTS];
    logic [AW-1:0] age_q [SLOTS];

    always_comb begin
        free_o = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (age_q[k] >= FULL) free_o = 1'b1;
        end
    end

    always_comb begin
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            age_d[k] = (age_q[k] >= FULL) ? FULL : age_q[k] + 1'b1;
            if (clr_i) begin
                age_d[k] = FULL;
            end else if (take_i && !hit && (age_q[k] >= FULL)) begin
                age_d[k] = AW'(1);
                hit      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < SLOTS; k++) begin
            if (rst) age_q[k] <= FULL;
            else     age_q[k] <= age_d[k];
        end
    end

endmodule

// File: rtl/cgf_chan.sv
module cgf_chan
    import cgf_pkg::*;
#(
    parameter int WIN        = 130,
    parameter int EDGES      = 2,
    parameter int MINW_FILT  = 3,
    parameter int MINW_PLAIN = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  cgf_mode_e mode_i,
    input  logic      raw_i,
    input  logic      smp_i,
    output logic      out_o
);
    localparam int CW = $clog2(cgf_max(MINW_FILT, MINW_PLAIN) + 1);
    localparam logic [CW-1:0] NEED_F = CW'(MINW_FILT);
    localparam logic [CW-1:0] NEED_P = CW'(MINW_PLAIN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } st_t;

    st_t           st_d, st_q;
    logic          take, win_free;
    logic [CW-1:0] need, inc;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        need = (mode_i == MODE_FILT) ? NEED_F : NEED_P;
        inc  = st_q.cnt + 1'b1;
        if (mode_i == MODE_BYPASS) begin
            st_d.lvl = raw_i;
            st_d.cnt = '0;
        end else if (smp_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (inc >= need) begin
            st_d.cnt = '0;
            if (win_free) begin
                st_d.lvl = smp_i;
                take     = 1'b1;
            end
        end else begin
            st_d.cnt = inc;
        end
    end

    cgf_window #(
        .WIN   (WIN),
        .SLOTS (EDGES)
    ) u_win (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (mode_i == MODE_BYPASS),
        .take_i (take),
        .free_o (win_free)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_o = st_q.lvl;

endmodule

// File: rtl/ctrl_glitch_filter.sv
module ctrl_glitch_filter
    import cgf_pkg::*;
#(
    parameter int WIN_LEN    = 130,
    parameter int FAST_CH    = 2,
    parameter int SLOW_CH    = 1,
    parameter int FAST_EDGES = 2,
    parameter int SLOW_EDGES = 1,
    parameter int FAST_MINW  = 3,
    parameter int SLOW_MINW  = 130
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       norm_mode_i,
    input  logic                       filt_en_i,
    input  logic [FAST_CH+SLOW_CH-1:0] ctl_i,
    output logic [FAST_CH+SLOW_CH-1:0] ctl_o
);
    localparam int NCH = FAST_CH + SLOW_CH;

    logic [NCH-1:0] smp_d, smp_q;
    cgf_mode_e      mode;

    always_comb begin
        smp_d = ctl_i;
        if (!norm_mode_i)   mode = MODE_BYPASS;
        else if (filt_en_i) mode = MODE_FILT;
        else                mode = MODE_PLAIN;
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= smp_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c < FAST_CH) begin : g_fast
            cgf_chan #(
                .WIN        (WIN_LEN),
                .EDGES      (FAST_EDGES),
                .MINW_FILT  (FAST_MINW),
                .MINW_PLAIN (1)
            ) u_ch (
                .clk    (clk),
                .rst    (rst),
                .mode_i (mode),
                .raw_i  (ctl_i[c]),
                .smp_i  (smp_q[c]),
                .out_o  (ctl_o[c])
            );
        end else begin : g_slow
            cgf_chan #(
                .WIN        (WIN_LEN),
                .EDGES      (SLOW_EDGES),
                .MINW_FILT  (SLOW_MINW),
                .MINW_PLAIN (SLOW_MINW)
            ) u_ch (
                .clk    (clk),
                .rst    (rst),
                .mode_i (mode),
                .raw_i  (ctl_i[c]),
                .smp_i  (smp_q[c]),
                .out_o  (ctl_o[c])
            );
        end
    end

endmodule

// File: rtl/cgf_chk.sv
module cgf_chk #(
    parameter int WIN_LEN    = 130,
    parameter int FAST_CH    = 2,
    parameter int SLOW_CH    = 1,
    parameter int FAST_EDGES = 2,
    parameter int SLOW_EDGES = 1,
    parameter int FAST_MINW  = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       norm_mode_i,
    input logic                       filt_en_i,
    input logic [FAST_CH+SLOW_CH-1:0] ctl_i,
    input logic [FAST_CH+SLOW_CH-1:0] ctl_o
);
    localparam int NCH = FAST_CH + SLOW_CH;
    localparam int GW  = $clog2(WIN_LEN + 1);
    localparam logic [GW-1:0] GMAX = GW'(WIN_LEN);

    // R1
    rst_low_chk: assert property (@(posedge clk) rst |=> ctl_o == '0);

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !norm_mode_i |=> ctl_o == $past(ctl_i));

    if (FAST_MINW == 3 && FAST_EDGES == 2 && SLOW_EDGES == 1
        && FAST_CH >= 1 && SLOW_CH >= 1) begin : g_rules
        logic [NCH-1:0] po_q;
        logic           pn_q, pf_q, prst_q;
        logic [GW-1:0]  gl_q, gp_q, gs_q;
        logic           chg_f, chg_s;

        function automatic logic [GW-1:0] sat_inc(input logic [GW-1:0] v);
            return (v >= GMAX) ? GMAX : v + 1'b1;
        endfunction

        assign chg_f = pn_q && !prst_q && (ctl_o[0] != po_q[0]);
        assign chg_s = pn_q && !prst_q && (ctl_o[FAST_CH] != po_q[FAST_CH]);

        always_ff @(posedge clk) begin
            po_q   <= ctl_o;
            pn_q   <= norm_mode_i;
            pf_q   <= filt_en_i;
            prst_q <= rst;
            if (rst || !norm_mode_i) begin
                gl_q <= GMAX;
                gp_q <= GMAX;
                gs_q <= GMAX;
            end else begin
                if (chg_f) begin
                    gl_q <= GW'(1);
                    gp_q <= sat_inc(gl_q);
                end else begin
                    gl_q <= sat_inc(gl_q);
                    gp_q <= sat_inc(gp_q);
                end
                gs_q <= chg_s ? GW'(1) : sat_inc(gs_q);
            end
        end

        // R3
        min_width_chk: assert property (@(posedge clk) disable iff (rst)
            (chg_f && pf_q) |->
            ($past(ctl_i[0], 2) == ctl_o[0] && $past(ctl_i[0], 3) == ctl_o[0]
             && $past(ctl_i[0], 4) == ctl_o[0]));

        // R6
        fast_window_chk: assert property (@(posedge clk) disable iff (rst)
            chg_f |-> gp_q >= GMAX);

        // R8
        slow_window_chk: assert property (@(posedge clk) disable iff (rst)
            chg_s |-> gs_q >= GMAX);
    end

endmodule

bind ctrl_glitch_filter cgf_chk #(
    .WIN_LEN    (WIN_LEN),
    .FAST_CH    (FAST_CH),
    .SLOW_CH    (SLOW_CH),
    .FAST_EDGES (FAST_EDGES),
    .SLOW_EDGES (SLOW_EDGES),
    .FAST_MINW  (FAST_MINW)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .norm_mode_i (norm_mode_i),
    .filt_en_i   (filt_en_i),
    .ctl_i       (ctl_i),
    .ctl_o       (ctl_o)
);

// File: tb/ctrl_glitch_filter_tb_top.sv
`timescale 1ns/1ps
module ctrl_glitch_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       norm = 1'b1;
    logic       en = 1'b1;
    logic [2:0] ctl_i = 3'b000;
    logic [2:0] ctl_o;

    int total = 0;
    int bad = 0;
    int unexp = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [2:0] prev = 3'b000;

    typedef struct {
        int         at;
        logic [2:0] val;
        string      req;
    } exp_t;
    exp_t sbq[$];

    ctrl_glitch_filter dut_i (
        .clk         (clk),
        .rst         (rst),
        .norm_mode_i (norm),
        .filt_en_i   (en),
        .ctl_i       (ctl_i),
        .ctl_o       (ctl_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pairs every output change with the queue head
    always @(negedge clk) begin
        if (rst) begin
            prev = ctl_o;
        end else if (ctl_o !== prev) begin
            total++;
            if (sbq.size() == 0) begin
                bad++;
                unexp++;
                $display("FAIL %s: unexpected change to %b at cycle %0d, expected no change",
                         cur_req, ctl_o, cyc);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.at != cyc || e.val !== ctl_o) begin
                    bad++;
                    $display("FAIL %s: got %b at cycle %0d, expected %b at cycle %0d",
                             e.req, ctl_o, cyc, e.val, e.at);
                end
            end
            prev = ctl_o;
        end
    end

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drive_at(input int t, input logic [2:0] v);
        wait_to(t);
        ctl_i = v;
    endtask

    task automatic push(input int t, input logic [2:0] v, input string r);
        exp_t e;
        e.at  = t;
        e.val = v;
        e.req = r;
        sbq.push_back(e);
    endtask

    task automatic start_phase(input logic n, input logic f, input string r,
                               output int b);
        @(negedge clk);
        rst = 1'b1;
        ctl_i = 3'b000;
        norm = n;
        en = f;
        cur_req = r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        b = cyc;
    endtask

    task automatic end_phase(input int t, input string r);
        wait_to(t);
        total++;
        if (sbq.size() != 0 || unexp != 0) begin
            bad++;
            $display("FAIL %s: %0d edges missing, %0d unexpected; expected 0 and 0",
                     r, sbq.size(), unexp);
        end
        sbq.delete();
        unexp = 0;
    endtask

    task automatic check_low(input string r);
        total++;
        if (ctl_o !== 3'b000) begin
            bad++;
            $display("FAIL %s: ctl_o=%b during reset, expected 000", r, ctl_o);
        end
    endtask

    initial begin
        int b;
        // R1: reset forces low with inputs high, in normal and bypass
        @(negedge clk);
        rst = 1'b1;
        ctl_i = 3'b111;
        norm = 1'b1;
        en = 1'b1;
        repeat (3) @(negedge clk);
        check_low("R1");
        norm = 1'b0;
        repeat (2) @(negedge clk);
        check_low("R1");

        // R2, R3, R4: filter on
        start_phase(1'b1, 1'b1, "R3", b);
        drive_at(b + 5, 3'b001);
        push(b + 9, 3'b001, "R2");
        drive_at(b + 8, 3'b000);
        push(b + 12, 3'b000, "R2");
        drive_at(b + 20, 3'b010);
        drive_at(b + 22, 3'b000);
        drive_at(b + 30, 3'b010);
        drive_at(b + 32, 3'b000);
        drive_at(b + 33, 3'b010);
        push(b + 37, 3'b010, "R4");
        end_phase(b + 60, "R3");

        // R5, R6: filter off, edge-count window
        start_phase(1'b1, 1'b0, "R6", b);
        drive_at(b + 5, 3'b001);
        push(b + 7, 3'b001, "R5");
        drive_at(b + 6, 3'b000);
        push(b + 8, 3'b000, "R5");
        drive_at(b + 10, 3'b010);
        push(b + 12, 3'b010, "R5");
        drive_at(b + 15, 3'b000);
        push(b + 17, 3'b000, "R5");
        drive_at(b + 20, 3'b001);
        drive_at(b + 25, 3'b000);
        drive_at(b + 40, 3'b010);
        push(b + 142, 3'b010, "R6");
        end_phase(b + 170, "R6");

        // R7, R8: slow line, filter setting off to show it has no effect
        start_phase(1'b1, 1'b0, "R7", b);
        drive_at(b + 5, 3'b100);
        drive_at(b + 100, 3'b000);
        drive_at(b + 110, 3'b100);
        push(b + 241, 3'b100, "R7");
        drive_at(b + 260, 3'b000);
        drive_at(b + 300, 3'b100);
        drive_at(b + 310, 3'b000);
        push(b + 441, 3'b000, "R8");
        end_phase(b + 470, "R7");

        // R9: bypass, filt_en ignored
        start_phase(1'b0, 1'b1, "R9", b);
        drive_at(b + 5, 3'b101);
        push(b + 6, 3'b101, "R9");
        drive_at(b + 6, 3'b010);
        push(b + 7, 3'b010, "R9");
        drive_at(b + 7, 3'b000);
        push(b + 8, 3'b000, "R9");
        wait_to(b + 10);
        en = 1'b0;
        drive_at(b + 12, 3'b111);
        push(b + 13, 3'b111, "R9");
        end_phase(b + 30, "R9");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL %s: watchdog expired at cycle %0d, expected completion", cur_req, cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule